// File: doc/BRIEF.md
# Acquisition Bridge Sequencer

This block is the central controller of a bridge that sits between a fast ADC front end and a slower host processor. On a host start command it runs one acquisition. It enables the capture block and waits for the samples to land in external memory. It then hands the stored record to the host in stages: the host asks for the data, the block fills a readout FIFO up to a fixed level, the host acknowledges, the block drains the rest of memory into the FIFO, and finally it waits until the host has taken every sample of the record.

The host drives the block through three self-clearing command bits (start, read request, read acknowledge), a three-bit interrupt mask and a write-one-to-clear port for the event flags. The block reports back through a seven-bit status word and one interrupt line. The status word carries the sequencer state in its low bits and four sticky event flags above them. The memory controller, the FIFOs and the host bus are outside this block. It sees them only as enable, done, level and fetch-strobe signals.

Top module: `acq_bridge_seq`

## Requirements
- R1: After a synchronous reset, status reads 0 and cap_en, drain_en, irq and samp_count are all 0. The mask and the latched command bits are also cleared.
- R2: Command bits written with ctrl_wr are latched from the next cycle until the state that uses them consumes them. The block leaves Idle only when the start bit is latched, mem_cal_done is high and no interrupt is outstanding. An interrupt is outstanding when status bit 3 is set, or when any of status bits 4, 5 or 6 is set together with its mask bit (mask bits 0, 1 and 2).
- R3: cap_en is high exactly while the state is Capture (code 1). The block stays in Capture until cap_done and then moves to Store (code 2).
- R4: A cap_done that comes with cap_forced set sets status bit 3 and pulses irq, whatever the mask holds.
- R5: In Store, store_done moves the block to Read-Request (code 3) and sets status bit 4. irq pulses if mask bit 0 is set.
- R6: In Read-Request, a latched read-request bit moves the block to Fill (code 4). On the same edge samp_count loads cap_count and the fetch tally restarts at zero.
- R7: In Fill, a fifo_level of at least 64 moves the block to Ack-Wait (code 5) and sets status bit 5. irq pulses if mask bit 1 is set. A lower level keeps it in Fill.
- R8: drain_en is high in Fill and in Drain (code 6) and low elsewhere. In Ack-Wait, drain_done has no effect, and a latched acknowledge bit moves the block to Drain. In Drain, drain_done moves it to Fetch (code 7).
- R9: host_fetch strobes are counted from the Read-Request exit onward. In Fetch, once the count reaches samp_count, the block returns to Idle and sets status bit 6. irq pulses if mask bit 2 is set. A zero samp_count leaves Fetch on its first cycle.
- R10: After every clock edge, status holds {flags, state code} for the new state. The exception is while the block sits in Read-Request: there status keeps the value written on entry, and it updates again one cycle after the exit.
- R11: Status bits 6:3 stay set until a flag_clr_wr with bit i of flag_clr set clears bit 3+i. A set and a clear of the same flag on the same edge leave the flag set.
- R12: irq is a one-cycle pulse, high in the cycle the new state first appears, and only for an enabled event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Command write strobe |
| ctrl_start | input | 1 | Start command bit |
| ctrl_rd_req | input | 1 | Read request command bit |
| ctrl_rd_ack | input | 1 | Read acknowledge command bit |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_data | input | 3 | Mask: bit0 stored, bit1 data ready, bit2 complete |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr | input | 4 | Write-one-to-clear for status bits 6:3 |
| mem_cal_done | input | 1 | External memory calibrated |
| cap_done | input | 1 | Capture finished |
| cap_forced | input | 1 | Capture ended by forced stop (qualified by cap_done) |
| cap_count | input | CNT_W | Number of samples actually captured |
| store_done | input | 1 | Record written to external memory |
| fifo_level | input | LVL_W | Readout FIFO occupancy |
| drain_done | input | 1 | Memory fully copied into readout FIFO |
| host_fetch | input | 1 | Host took one sample |
| cap_en | output | 1 | Capture enable |
| drain_en | output | 1 | Memory-to-FIFO copy enable |
| samp_count | output | CNT_W | Latched sample count |
| status | output | 7 | {flags[3:0], state[2:0]} |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest behaviour to reach is the status freeze in Read-Request combined with flag traffic. A flag cleared while the block waits for the read request must stay invisible until one cycle after the exit. Idle must also refuse to start while a masked-in flag is still set, and the refusal must end as soon as the host clears that flag. Directed sequences force each of these: a clear during Read-Request, a start while the completion flag is pending, a forced stop that coincides with a clear of its own flag, and a zero sample count. A long seeded random run then keeps strobes, clears and mask rewrites colliding with every state, and checks each cycle against a reference model held in the bench.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CAPTURE = 3'd1,
        ST_STORE   = 3'd2,
        ST_RDREQ   = 3'd3,
        ST_FILL    = 3'd4,
        ST_ACKWAIT = 3'd5,
        ST_DRAIN   = 3'd6,
        ST_FETCH   = 3'd7
    } seq_state_e;

    // event flag positions (status bit = 3 + index)
    localparam int EVT_N      = 4;
    localparam int EVT_FORCED = 0;
    localparam int EVT_STORED = 1;
    localparam int EVT_AVAIL  = 2;
    localparam int EVT_DONE   = 3;
    localparam int MASK_W     = EVT_N - 1;

    // host command bit positions
    localparam int CTL_N     = 3;
    localparam int CTL_START = 0;
    localparam int CTL_RDREQ = 1;
    localparam int CTL_ACK   = 2;

    typedef struct packed {
        logic [EVT_N-1:0] flags;
        seq_state_e       state;
    } seq_status_t;

    localparam int STAT_W = $bits(seq_status_t);

    // forced-stop event is never masked
    function automatic logic [EVT_N-1:0] evt_enables(input logic [MASK_W-1:0] mask);
        return {mask, 1'b1};
    endfunction

    function automatic logic irq_outstanding(input logic [EVT_N-1:0] flags,
                                             input logic [MASK_W-1:0] mask);
        return |(flags & evt_enables(mask));
    endfunction

endpackage

// File: rtl/acq_host_ctrl.sv
module acq_host_ctrl
    import acq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTL_N-1:0]  ctrl_bits,
    input  logic [CTL_N-1:0]  consume,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_data,
    output logic [CTL_N-1:0]  pend,
    output logic [MASK_W-1:0] mask
);

    for (genvar i = 0; i < CTL_N; i++) begin : g_cmd
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (ctrl_wr && ctrl_bits[i]) begin
                bit_q <= 1'b1;
            end else if (consume[i]) begin
                bit_q <= 1'b0;
            end
        end

        assign pend[i] = bit_q;

        // R2: a latched command bit survives until consumed
        p_cmd_hold_r2: assert property (@(posedge clk) disable iff (rst)
            (bit_q && !consume[i]) |=> bit_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (mask_wr) begin
            mask <= mask_data;
        end
    end

endmodule

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
    import acq_seq_pkg::*;
#(
    parameter int LVL_W       = 8,
    parameter int FILL_THRESH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTL_N-1:0] pend,
    input  logic             mem_cal_done,
    input  logic             irq_busy,
    input  logic             cap_done,
    input  logic             cap_forced,
    input  logic             store_done,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             drain_done,
    input  logic             fetch_done,
    output seq_state_e       state_q,
    output seq_state_e       state_d,
    output logic [CTL_N-1:0] consume,
    output logic [EVT_N-1:0] events,
    output logic             accept,
    output logic             cap_en,
    output logic             drain_en
);

    localparam logic [LVL_W:0] THRESH_V = (LVL_W + 1)'(FILL_THRESH);

    logic fifo_full_enough;
    assign fifo_full_enough = ({1'b0, fifo_level} >= THRESH_V);

    always_comb begin
        state_d = state_q;
        consume = '0;
        events  = '0;
        accept  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (pend[CTL_START] && mem_cal_done && !irq_busy) begin
                    state_d            = ST_CAPTURE;
                    consume[CTL_START] = 1'b1;
                end
            end
            ST_CAPTURE: begin
                if (cap_done) begin
                    state_d            = ST_STORE;
                    events[EVT_FORCED] = cap_forced;
                end
            end
            ST_STORE: begin
                if (store_done) begin
                    state_d            = ST_RDREQ;
                    events[EVT_STORED] = 1'b1;
                end
            end
            ST_RDREQ: begin
                if (pend[CTL_RDREQ]) begin
                    state_d            = ST_FILL;
                    consume[CTL_RDREQ] = 1'b1;
                    accept             = 1'b1;
                end
            end
            ST_FILL: begin
                if (fifo_full_enough) begin
                    state_d           = ST_ACKWAIT;
                    events[EVT_AVAIL] = 1'b1;
                end
            end
            ST_ACKWAIT: begin
                if (pend[CTL_ACK]) begin
                    state_d          = ST_DRAIN;
                    consume[CTL_ACK] = 1'b1;
                end
            end
            ST_DRAIN: begin
                if (drain_done) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (fetch_done) begin
                    state_d          = ST_IDLE;
                    events[EVT_DONE] = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign cap_en   = (state_q == ST_CAPTURE);
    assign drain_en = (state_q == ST_FILL) || (state_q == ST_DRAIN);

    // R2: Idle exit only with start, calibration and nothing outstanding
    p_idle_exit_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE && $past(state_q) == ST_IDLE)
            |-> $past(pend[CTL_START] && mem_cal_done && !irq_busy));

    // R3: capture holds until done
    p_capture_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE && !cap_done) |=> (state_q == ST_CAPTURE));

    // R6: read-request waits for the host
    p_rdreq_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RDREQ && !pend[CTL_RDREQ]) |=> (state_q == ST_RDREQ));

    // R8: Fetch is entered only from Drain on drain_done
    p_drain_exit_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && $past(state_q) != ST_FETCH)
            |-> ($past(state_q) == ST_DRAIN && $past(drain_done)));

endmodule

// File: rtl/acq_fetch_tally.sv
module acq_fetch_tally #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [CNT_W-1:0] cap_count,
    input  logic             host_fetch,
    output logic [CNT_W-1:0] samp_count,
    output logic             fetch_done
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] fetched_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_count <= '0;
            fetched_q  <= '0;
        end else if (accept) begin
            samp_count <= cap_count;
            fetched_q  <= '0;
        end else if (host_fetch && fetched_q != CNT_MAX) begin
            fetched_q  <= fetched_q + 1'b1;
        end
    end

    assign fetch_done = (fetched_q >= samp_count);

    // R9: the tally never goes backwards except on restart
    p_tally_up_r9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> (fetched_q >= $past(fetched_q)));

    // R6: restart clears the tally and loads the count
    p_tally_load_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> (fetched_q == '0 && samp_count == $past(cap_count)));

endmodule

// File: rtl/acq_event_flags.sv
module acq_event_flags
    import acq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_N-1:0]  events,
    input  logic [MASK_W-1:0] mask,
    input  logic              clr_wr,
    input  logic [EVT_N-1:0]  clr,
    input  seq_state_e        state_q,
    input  seq_state_e        state_d,
    output logic              irq_busy,
    output logic              irq,
    output seq_status_t       status
);

    logic [EVT_N-1:0] flags_q;
    logic [EVT_N-1:0] flags_d;
    logic             irq_d;
    seq_status_t      status_d;

    always_comb begin
        flags_d = (flags_q & ~(clr_wr ? clr : '0)) | events;
        irq_d   = |(events & evt_enables(mask));
        if (state_q == ST_RDREQ) begin
            status_d = status;
        end else begin
            status_d = '{flags: flags_d, state: state_d};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            irq     <= 1'b0;
            status  <= '0;
        end else begin
            flags_q <= flags_d;
            irq     <= irq_d;
            status  <= status_d;
        end
    end

    assign irq_busy = irq_outstanding(flags_q, mask);

    for (genvar i = 0; i < EVT_N; i++) begin : g_sticky
        // R11: a flag stays set unless cleared
        p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !(clr_wr && clr[i])) |=> flags_q[i]);
    end

    // R10: status is frozen while waiting for the read request
    p_status_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RDREQ) |=> $stable(status));

    // R4: forced stop always interrupts
    p_forced_irq_r4: assert property (@(posedge clk) disable iff (rst)
        events[EVT_FORCED] |=> irq);

endmodule

// File: rtl/acq_bridge_seq.sv
module acq_bridge_seq
    import acq_seq_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int LVL_W       = 8,
    parameter int FILL_THRESH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              ctrl_start,
    input  logic              ctrl_rd_req,
    input  logic              ctrl_rd_ack,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_data,
    input  logic              flag_clr_wr,
    input  logic [EVT_N-1:0]  flag_clr,
    input  logic              mem_cal_done,
    input  logic              cap_done,
    input  logic              cap_forced,
    input  logic [CNT_W-1:0]  cap_count,
    input  logic              store_done,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              drain_done,
    input  logic              host_fetch,
    output logic              cap_en,
    output logic              drain_en,
    output logic [CNT_W-1:0]  samp_count,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic [CTL_N-1:0]  ctrl_bits;
    logic [CTL_N-1:0]  pend;
    logic [CTL_N-1:0]  consume;
    logic [MASK_W-1:0] mask;
    logic [EVT_N-1:0]  events;
    logic              accept;
    logic              fetch_done;
    logic              irq_busy;
    seq_state_e        state_q;
    seq_state_e        state_d;
    seq_status_t       status_s;

    always_comb begin
        ctrl_bits            = '0;
        ctrl_bits[CTL_START] = ctrl_start;
        ctrl_bits[CTL_RDREQ] = ctrl_rd_req;
        ctrl_bits[CTL_ACK]   = ctrl_rd_ack;
    end

    acq_host_ctrl u_host (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (ctrl_bits),
        .consume   (consume),
        .mask_wr   (mask_wr),
        .mask_data (mask_data),
        .pend      (pend),
        .mask      (mask)
    );

    acq_seq_fsm #(
        .LVL_W       (LVL_W),
        .FILL_THRESH (FILL_THRESH)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pend         (pend),
        .mem_cal_done (mem_cal_done),
        .irq_busy     (irq_busy),
        .cap_done     (cap_done),
        .cap_forced   (cap_forced),
        .store_done   (store_done),
        .fifo_level   (fifo_level),
        .drain_done   (drain_done),
        .fetch_done   (fetch_done),
        .state_q      (state_q),
        .state_d      (state_d),
        .consume      (consume),
        .events       (events),
        .accept       (accept),
        .cap_en       (cap_en),
        .drain_en     (drain_en)
    );

    acq_fetch_tally #(
        .CNT_W (CNT_W)
    ) u_tally (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .cap_count  (cap_count),
        .host_fetch (host_fetch),
        .samp_count (samp_count),
        .fetch_done (fetch_done)
    );

    acq_event_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .events   (events),
        .mask     (mask),
        .clr_wr   (flag_clr_wr),
        .clr      (flag_clr),
        .state_q  (state_q),
        .state_d  (state_d),
        .irq_busy (irq_busy),
        .irq      (irq),
        .status   (status_s)
    );

    assign status = status_s;

    // R12: an interrupt only accompanies a change of reported state
    p_irq_on_change_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_s.state != $past(status_s.state)));

    // R9: return from Fetch only after all samples were taken
    p_fetch_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && $past(state_q) == ST_FETCH) |-> $past(fetch_done));

endmodule

// File: tb/acq_bridge_seq_bench.sv
module acq_bridge_seq_bench;

    localparam int CNT_W = 24;
    localparam int LVL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ctrl_wr = 0, ctrl_start = 0, ctrl_rd_req = 0, ctrl_rd_ack = 0;
    logic             mask_wr = 0;
    logic [2:0]       mask_data = '0;
    logic             flag_clr_wr = 0;
    logic [3:0]       flag_clr = '0;
    logic             mem_cal_done = 0, cap_done = 0, cap_forced = 0;
    logic [CNT_W-1:0] cap_count = '0;
    logic             store_done = 0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             drain_done = 0, host_fetch = 0;
    logic             cap_en, drain_en, irq;
    logic [CNT_W-1:0] samp_count;
    logic [6:0]       status;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    logic [2:0]       m_state;
    logic             m_start, m_rdreq, m_ack, m_irq;
    logic [2:0]       m_mask;
    logic [3:0]       m_flags;
    logic [6:0]       m_status;
    logic [CNT_W-1:0] m_count, m_fetched;

    always #5 clk = ~clk;

    acq_bridge_seq u_acq_bridge_seq (
        .clk(clk), .rst(rst),
        .ctrl_wr(ctrl_wr), .ctrl_start(ctrl_start), .ctrl_rd_req(ctrl_rd_req),
        .ctrl_rd_ack(ctrl_rd_ack), .mask_wr(mask_wr), .mask_data(mask_data),
        .flag_clr_wr(flag_clr_wr), .flag_clr(flag_clr), .mem_cal_done(mem_cal_done),
        .cap_done(cap_done), .cap_forced(cap_forced), .cap_count(cap_count),
        .store_done(store_done), .fifo_level(fifo_level), .drain_done(drain_done),
        .host_fetch(host_fetch), .cap_en(cap_en), .drain_en(drain_en),
        .samp_count(samp_count), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic model_step();
        logic [2:0] ns;
        logic [3:0] ev;
        logic       s_c, r_c, a_c, acc, busy;
        logic [3:0] nf;
        if (rst) begin
            m_state = 0; m_start = 0; m_rdreq = 0; m_ack = 0; m_irq = 0;
            m_mask = 0; m_flags = 0; m_status = 0; m_count = 0; m_fetched = 0;
            return;
        end
        ns = m_state; ev = 0; s_c = 0; r_c = 0; a_c = 0; acc = 0;
        busy = m_flags[0] | (|(m_flags[3:1] & m_mask));
        case (m_state)
            3'd0: if (m_start && mem_cal_done && !busy) begin ns = 1; s_c = 1; end
            3'd1: if (cap_done) begin ns = 2; ev[0] = cap_forced; end
            3'd2: if (store_done) begin ns = 3; ev[1] = 1; end
            3'd3: if (m_rdreq) begin ns = 4; r_c = 1; acc = 1; end
            3'd4: if (fifo_level >= 64) begin ns = 5; ev[2] = 1; end
            3'd5: if (m_ack) begin ns = 6; a_c = 1; end
            3'd6: if (drain_done) ns = 7;
            default: if (m_fetched >= m_count) begin ns = 0; ev[3] = 1; end
        endcase
        m_irq = |(ev & {m_mask, 1'b1});
        nf = (m_flags & ~(flag_clr_wr ? flag_clr : 4'b0)) | ev;
        if (m_state != 3) m_status = {nf, ns};
        m_start = (ctrl_wr && ctrl_start)  ? 1'b1 : (m_start && !s_c);
        m_rdreq = (ctrl_wr && ctrl_rd_req) ? 1'b1 : (m_rdreq && !r_c);
        m_ack   = (ctrl_wr && ctrl_rd_ack) ? 1'b1 : (m_ack && !a_c);
        if (mask_wr) m_mask = mask_data;
        if (acc) begin
            m_count = cap_count; m_fetched = 0;
        end else if (host_fetch && m_fetched != {CNT_W{1'b1}}) begin
            m_fetched = m_fetched + 1;
        end
        m_flags = nf;
        m_state = ns;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        if (!rst) begin
            chk("R10 status vs model", 32'(status), 32'(m_status));
            chk("R3 cap_en vs model", 32'(cap_en), 32'(m_state == 3'd1));
            chk("R8 drain_en vs model", 32'(drain_en), 32'(m_state == 3'd4 || m_state == 3'd6));
            chk("R12 irq vs model", 32'(irq), 32'(m_irq));
            chk("R6 samp_count vs model", 32'(samp_count), 32'(m_count));
        end
        ctrl_wr = 0; ctrl_start = 0; ctrl_rd_req = 0; ctrl_rd_ack = 0;
        mask_wr = 0; flag_clr_wr = 0; cap_done = 0; store_done = 0;
        drain_done = 0; host_fetch = 0;
    endtask

    task automatic cmd(input logic s, input logic r, input logic a);
        ctrl_wr = 1; ctrl_start = s; ctrl_rd_req = r; ctrl_rd_ack = a;
        tick();
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7741));
        repeat (3) tick();
        rst = 0;
        // R1 reset state
        chk("R1 status", 32'(status), 32'h00);
        chk("R1 cap_en", 32'(cap_en), 0);
        chk("R1 drain_en", 32'(drain_en), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 samp_count", 32'(samp_count), 0);

        // R2: no calibration -> stay idle
        cmd(1, 0, 0); tick(); tick();
        chk("R2 idle without cal", 32'(status), 32'h00);
        mem_cal_done = 1; tick();
        chk("R2 start accepted", 32'(status), 32'h01);
        chk("R3 cap_en in capture", 32'(cap_en), 1);
        tick(); tick(); tick();
        chk("R3 capture holds", 32'(status), 32'h01);

        // R4 forced stop, mask all zero
        cap_done = 1; cap_forced = 1; tick();
        chk("R4 forced status", 32'(status), 32'h0A);
        chk("R4 forced irq", 32'(irq), 1);
        chk("R3 cap_en dropped", 32'(cap_en), 0);
        cap_forced = 0; tick();
        chk("R12 irq single cycle", 32'(irq), 0);

        // R5 store done with mask bit 0
        mask_wr = 1; mask_data = 3'b111; tick();
        store_done = 1; tick();
        chk("R5 store status", 32'(status), 32'h1B);
        chk("R5 store irq", 32'(irq), 1);

        // R10 freeze during read-request
        flag_clr_wr = 1; flag_clr = 4'b0001; tick();
        chk("R10 frozen after clear", 32'(status), 32'h1B);
        cap_count = 5; cmd(0, 1, 0); tick();
        chk("R10 frozen on exit", 32'(status), 32'h1B);
        chk("R6 count loaded", 32'(samp_count), 5);
        chk("R6 drain_en in fill", 32'(drain_en), 1);
        tick();
        chk("R10 updates after exit", 32'(status), 32'h14);

        // R7 threshold
        fifo_level = 63; tick();
        chk("R7 below threshold", 32'(status), 32'h14);
        fifo_level = 64; tick();
        chk("R7 at threshold", 32'(status), 32'h35);
        chk("R7 irq", 32'(irq), 1);
        chk("R8 drain_en off in ackwait", 32'(drain_en), 0);

        // R8 drain_done ignored before ack
        drain_done = 1; tick();
        chk("R8 drain_done ignored", 32'(status), 32'h35);
        cmd(0, 0, 1); tick();
        chk("R8 ack to drain", 32'(status), 32'h36);
        chk("R8 drain_en in drain", 32'(drain_en), 1);
        repeat (3) begin host_fetch = 1; tick(); end
        drain_done = 1; tick();
        chk("R8 drain to fetch", 32'(status), 32'h37);

        // R9 fetch completion
        tick();
        chk("R9 waits for fetches", 32'(status), 32'h37);
        host_fetch = 1; tick();
        host_fetch = 1; tick();
        chk("R9 not yet done", 32'(status), 32'h37);
        tick();
        chk("R9 complete", 32'(status), 32'h70);
        chk("R9 complete irq", 32'(irq), 1);

        // R2 blocked by outstanding interrupt, R11 clear releases
        cmd(1, 0, 0); tick();
        chk("R2 blocked by pending irq", 32'(status), 32'h70);
        flag_clr_wr = 1; flag_clr = 4'b1111; tick();
        chk("R11 flags cleared", 32'(status), 32'h00);
        tick();
        chk("R2 start after clear", 32'(status), 32'h01);

        // R11 set wins over clear
        cap_done = 1; cap_forced = 1; flag_clr_wr = 1; flag_clr = 4'b0001; tick();
        chk("R11 set beats clear", 32'(status), 32'h0A);
        cap_forced = 0;

        // R9 zero count
        store_done = 1; tick();
        cap_count = 0; cmd(0, 1, 0); tick();
        chk("R6 zero count loaded", 32'(samp_count), 0);
        tick();
        chk("R7 immediate fill", 32'(status), 32'h3D);
        cmd(0, 0, 1); tick();
        drain_done = 1; tick();
        chk("R8 fetch entered", 32'(status), 32'h3F);
        tick();
        chk("R9 zero count exit", 32'(status), 32'h78);

        // constrained random phase
        for (int k = 0; k < 3000; k++) begin
            ctrl_wr     = ($urandom % 4) == 0;
            ctrl_start  = $urandom % 2;
            ctrl_rd_req = $urandom % 2;
            ctrl_rd_ack = $urandom % 2;
            mask_wr     = ($urandom % 16) == 0;
            mask_data   = 3'($urandom);
            flag_clr_wr = ($urandom % 8) == 0;
            flag_clr    = 4'($urandom);
            mem_cal_done = ($urandom % 8) != 0;
            cap_done    = ($urandom % 6) == 0;
            cap_forced  = $urandom % 2;
            store_done  = ($urandom % 6) == 0;
            drain_done  = ($urandom % 6) == 0;
            host_fetch  = $urandom % 2;
            fifo_level  = 8'($urandom % 128);
            cap_count   = CNT_W'($urandom % 16);
            tick();
        end
        finish_run();
    end

endmodule